// File: doc/BRIEF.md
# Dual-Output Hitless Clock Divider

This block takes a fast oscillator clock and produces two slower clocks from it. Each output has its own divider, and a 3-bit code picks that divider's ratio from a fixed set. Both dividers count against one shared phase counter, so whenever two outputs run at ratios with a common multiple, their rising edges fall on the same oscillator edge. The second output can take its clock from either divider, so the two outputs can run at the same rate or at different rates.

A change of ratio never produces a runt pulse. The divider finishes the period it is in, drives low, and starts the first high phase at the new ratio only when the shared counter reaches a multiple of the new ratio. A global force-low input parks every enabled output low while the counter keeps running. A per-output enable turns that output off. This is shown on a separate output-enable flag, and the clock line is held low. The enable takes priority over force-low.

Ratio 1 passes the oscillator clock through a gate whose enable changes only while the oscillator is low. All other ratios come from a registered level. Every control input takes effect in the oscillator cycle that follows the next rising edge.

Top module: `clkdiv_dual`

## Requirements
- R1: Code 000 selects ratio 1. The output is then high during the high half of each oscillator cycle and low during the low half.
- R2: The other codes select these ratios: 001 = 2, 010 = 3, 011 = 4, 100 = 5, 101 = 6, 110 = 8, 111 = 16. For a ratio N above 1, each period is N oscillator cycles long: first floor(N/2) cycles high, then the remaining cycles low.
- R3: After a ratio change, the output completes its current period at the old ratio. It then stays low until the first cycle in which the shared phase counter is a multiple of the new ratio, and a high phase at the new ratio begins in that cycle.
- R4: A shared phase counter runs from 0 to 239 and then wraps to 0. Every period of every divider starts on a counter value that is a multiple of its ratio. This keeps the rising edges of both outputs coincident.
- R5: The ratio code is bits [7:5] of each 8-bit divider configuration input. Bits [4:0] have no effect on either output.
- R6: When the source select is 0, output 1 carries divider 0. When it is 1, output 1 carries divider 1. Output 0 always carries divider 0.
- R7: While force-low is set, every enabled output is held low with its enable flag high. The phase counter keeps running, so the waveform resumes in phase when force-low clears.
- R8: A cleared per-output enable drives that output's enable flag low and holds its clock line low, whatever the force-low input is.
- R9: During reset, both clock lines are low and both enable flags are high. After reset, both dividers run at ratio 1 and the phase counter starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous active-high reset |
| div0_cfg_i | input | 8 | Divider 0 configuration; ratio code in bits [7:5] |
| div1_cfg_i | input | 8 | Divider 1 configuration; ratio code in bits [7:5] |
| out1_src_i | input | 1 | Source for output 1: 0 = divider 0, 1 = divider 1 |
| force_low_i | input | 1 | Hold all enabled outputs low |
| out0_en_i | input | 1 | Enable for output 0 |
| out1_en_i | input | 1 | Enable for output 1 |
| clk0_o | output | 1 | Divided clock 0 |
| clk1_o | output | 1 | Divided clock 1 |
| oe0_o | output | 1 | Output 0 enable flag (low means high impedance) |
| oe1_o | output | 1 | Output 1 enable flag (low means high impedance) |

## Verification
The outputs are sampled twice in every oscillator cycle, once in the high half and once in the low half. This separates the pass-through ratio from a level held high, and it catches a pulse that is too short. The ratio pairs include an odd ratio against an even one (3 with 2, 5 with 4), two ratios with a large common multiple (6 with 8), and the extreme pair 16 with 1. These patterns separate a wrong high-phase length, a misaligned counter and a wrong code map. Ratio changes land at varying phases of the running period. This exercises both the case where the old period ends on a new-ratio boundary and the case where it must hold low, and a hold that is too short or a truncated period shows up at once. Configuration bytes that differ only in their low bits, plus combinations of source select, force-low and enables, including force-low with an output disabled, separate routing and priority faults.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int CODE_W    = 3;
    localparam int PHASE_MOD = 240;
    localparam int PHASE_W   = $clog2(PHASE_MOD);

    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [PHASE_W-1:0] phase_t;

    typedef enum logic {
        DIV_RUN  = 1'b0,
        DIV_HOLD = 1'b1
    } div_state_e;

    typedef struct packed {
        logic lvl;
        logic pass;
    } tap_t;

    function automatic phase_t ratio_of(code_t c);
        case (c)
            3'd0:    return phase_t'(1);
            3'd1:    return phase_t'(2);
            3'd2:    return phase_t'(3);
            3'd3:    return phase_t'(4);
            3'd4:    return phase_t'(5);
            3'd5:    return phase_t'(6);
            3'd6:    return phase_t'(8);
            default: return phase_t'(16);
        endcase
    endfunction

    function automatic phase_t phase_in(phase_t cnt, code_t c);
        case (c)
            3'd0:    return '0;
            3'd1:    return cnt % phase_t'(2);
            3'd2:    return cnt % phase_t'(3);
            3'd3:    return cnt % phase_t'(4);
            3'd4:    return cnt % phase_t'(5);
            3'd5:    return cnt % phase_t'(6);
            3'd6:    return cnt % phase_t'(8);
            default: return cnt % phase_t'(16);
        endcase
    endfunction

    function automatic tap_t shape_at(phase_t ph, code_t c);
        tap_t t;
        t.pass = (c == '0);
        t.lvl  = (c != '0) && (ph < (ratio_of(c) >> 1));
        return t;
    endfunction

endpackage

// File: rtl/clkdiv_phase_ctr.sv
module clkdiv_phase_ctr
    import clkdiv_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    output phase_t phase_o
);

    localparam phase_t LAST = phase_t'(PHASE_MOD - 1);

    always_ff @(posedge clk_i) begin
        if (rst_i)                phase_o <= '0;
        else if (phase_o == LAST) phase_o <= '0;
        else                      phase_o <= phase_o + phase_t'(1);
    end

    // R4: counter either wraps to zero or advances by exactly one
    assert_phase_step_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_o == '0) || (phase_o == $past(phase_o) + phase_t'(1)));

endmodule

// File: rtl/clkdiv_ratio_core.sv
module clkdiv_ratio_core
    import clkdiv_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  code_t  code_i,
    input  phase_t phase_i,
    output tap_t   tap_o
);

    code_t      act_q, act_d;
    div_state_e st_q, st_d;
    phase_t     ph_act, ph_new;
    logic       take_new;

    always_comb begin
        act_d    = act_q;
        st_d     = st_q;
        tap_o    = '0;
        take_new = 1'b0;
        ph_act   = phase_in(phase_i, act_q);
        ph_new   = phase_in(phase_i, code_i);
        if (st_q == DIV_RUN) begin
            if ((code_i != act_q) && (ph_act == '0)) begin
                if (ph_new == '0) take_new = 1'b1;
                else              st_d     = DIV_HOLD;
            end else begin
                tap_o = shape_at(ph_act, act_q);
            end
        end else if (ph_new == '0) begin
            take_new = 1'b1;
        end
        if (take_new) begin
            act_d = code_i;
            st_d  = DIV_RUN;
            tap_o = shape_at('0, code_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            act_q <= '0;
            st_q  <= DIV_RUN;
        end else begin
            act_q <= act_d;
            st_q  <= st_d;
        end
    end

    // R3: a new ratio is adopted only on a boundary of that new ratio
    assert_adopt_on_boundary_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (act_q != $past(act_q)) |-> (phase_in($past(phase_i), act_q) == '0));

endmodule

// File: rtl/clkdiv_out_stage.sv
module clkdiv_out_stage
    import clkdiv_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  tap_t tap_i,
    input  logic force_i,
    input  logic en_i,
    output logic clk_o,
    output logic oe_o
);

    logic live;
    logic lvl_q;
    logic gate_q;

    assign live = en_i & ~force_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lvl_q <= 1'b0;
            oe_o  <= 1'b1;
        end else begin
            lvl_q <= live & tap_i.lvl;
            oe_o  <= en_i;
        end
    end

    // gate for the pass-through ratio changes only while the oscillator is low
    always_ff @(negedge clk_i) begin
        if (rst_i) gate_q <= 1'b0;
        else       gate_q <= live & tap_i.pass;
    end

    assign clk_o = lvl_q | (clk_i & gate_q);

    // R1: the pass-through request and the divided level never coincide
    assert_pass_excl_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        tap_i.pass |-> !tap_i.lvl);

    // R7 / R8: a forced or disabled output keeps its pass gate closed
    assert_quiet_gate_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (force_i || !en_i) |-> !gate_q);

endmodule

// File: rtl/clkdiv_dual.sv
module clkdiv_dual
    import clkdiv_pkg::*;
#(
    parameter int CFG_W    = 8,
    parameter int CODE_LSB = 5
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CFG_W-1:0] div0_cfg_i,
    input  logic [CFG_W-1:0] div1_cfg_i,
    input  logic             out1_src_i,
    input  logic             force_low_i,
    input  logic             out0_en_i,
    input  logic             out1_en_i,
    output logic             clk0_o,
    output logic             clk1_o,
    output logic             oe0_o,
    output logic             oe1_o
);

    localparam int CODE_MSB = CODE_LSB + CODE_W - 1;
    localparam int N_DIV    = 2;

    phase_t     phase;
    code_t      codes [N_DIV];
    tap_t       taps  [N_DIV];
    tap_t       route [N_DIV];
    logic [N_DIV-1:0] en_v;
    logic [N_DIV-1:0] clk_v;
    logic [N_DIV-1:0] oe_v;
    logic       cfg_unused;

    assign codes[0]   = div0_cfg_i[CODE_MSB:CODE_LSB];
    assign codes[1]   = div1_cfg_i[CODE_MSB:CODE_LSB];
    assign cfg_unused = ^{div0_cfg_i[CODE_LSB-1:0], div1_cfg_i[CODE_LSB-1:0]};

    assign route[0] = taps[0];
    assign route[1] = out1_src_i ? taps[1] : taps[0];
    assign en_v     = {out1_en_i, out0_en_i};

    clkdiv_phase_ctr u_phase (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .phase_o (phase)
    );

    for (genvar g = 0; g < N_DIV; g++) begin : g_div
        clkdiv_ratio_core u_core (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .code_i  (codes[g]),
            .phase_i (phase),
            .tap_o   (taps[g])
        );

        clkdiv_out_stage u_out (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .tap_i   (route[g]),
            .force_i (force_low_i),
            .en_i    (en_v[g]),
            .clk_o   (clk_v[g]),
            .oe_o    (oe_v[g])
        );
    end

    assign clk0_o = clk_v[0];
    assign clk1_o = clk_v[1];
    assign oe0_o  = oe_v[0];
    assign oe1_o  = oe_v[1];

endmodule

// File: tb/tb_clkdiv_dual.sv
module tb_clkdiv_dual;

    typedef struct packed {
        logic [7:0] c0;
        logic [7:0] c1;
        logic       s;
        logic       f;
        logic       e0;
        logic       e1;
        logic [7:0] len;
        logic [3:0] kind;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'd20, 4'd1}, // R1 pass-through
        '{8'h20, 8'h40, 1'b1, 1'b0, 1'b1, 1'b1, 8'd33, 4'd2}, // R2 ratios 2 and 3
        '{8'h80, 8'h60, 1'b1, 1'b0, 1'b1, 1'b1, 8'd41, 4'd3}, // R3 change mid-period to 5 and 4
        '{8'hA0, 8'hC0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd47, 4'd4}, // R4 ratios 6 and 8 aligned
        '{8'hA0, 8'hC0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd30, 4'd6}, // R6 output 1 back on divider 0
        '{8'h3F, 8'hF5, 1'b1, 1'b0, 1'b1, 1'b1, 8'd50, 4'd5}, // R5 low bits set
        '{8'h3A, 8'hF0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd25, 4'd5}, // R5 low bits changed only
        '{8'h3A, 8'hF0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd20, 4'd7}, // R7 force-low
        '{8'h3A, 8'hF0, 1'b1, 1'b1, 1'b0, 1'b1, 8'd15, 4'd8}, // R8 disable beats force-low
        '{8'h60, 8'hE0, 1'b1, 1'b0, 1'b1, 1'b0, 8'd40, 4'd8}, // R8 output 1 disabled
        '{8'h00, 8'h80, 1'b1, 1'b0, 1'b1, 1'b1, 8'd35, 4'd3}, // R3 switch to 1 and to 5
        '{8'hE0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 8'd60, 4'd2}  // R2 ratios 16 and 1
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] d0 = 8'h00;
    logic [7:0] d1 = 8'h00;
    logic       s  = 1'b0;
    logic       f  = 1'b0;
    logic       e0 = 1'b1;
    logic       e1 = 1'b1;
    logic       clk0, clk1, oe0, oe1;

    int n_chk = 0;
    int n_err = 0;
    int mact [2];
    int mhold [2];
    int mc;
    logic [3:0] exp_hi_cur, exp_lo_cur, exp_hi_nxt, exp_lo_nxt;

    always #10 clk = ~clk;

    clkdiv_dual dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .div0_cfg_i  (d0),
        .div1_cfg_i  (d1),
        .out1_src_i  (s),
        .force_low_i (f),
        .out0_en_i   (e0),
        .out1_en_i   (e1),
        .clk0_o      (clk0),
        .clk1_o      (clk1),
        .oe0_o       (oe0),
        .oe1_o       (oe1)
    );

    function automatic int rat(int c);
        case (c)
            0: return 1;  1: return 2;  2: return 3;  3: return 4;
            4: return 5;  5: return 6;  6: return 8;  default: return 16;
        endcase
    endfunction

    function automatic string tag_of(logic [3:0] k);
        case (k)
            4'd1: return "R1"; 4'd2: return "R2"; 4'd3: return "R3";
            4'd4: return "R4"; 4'd5: return "R5"; 4'd6: return "R6";
            4'd7: return "R7"; default: return "R8";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s at %0t: {clk0,clk1,oe0,oe1} got %b expected %b", tag, $time, got, exp);
        end
    endtask

    // expected outputs for the cycle after the coming rising edge
    task automatic model_step();
        logic [1:0] lv, ps;
        logic [3:0] hi, lo;
        for (int d = 0; d < 2; d++) begin
            int c, na, nn, pa, pn, ph, nsel;
            logic take;
            c    = (d == 0) ? int'(d0[7:5]) : int'(d1[7:5]);
            na   = rat(mact[d]);
            nn   = rat(c);
            pa   = mc % na;
            pn   = mc % nn;
            take = 1'b0;
            lv[d] = 1'b0;
            ps[d] = 1'b0;
            ph    = pa;
            nsel  = na;
            if (mhold[d] == 0) begin
                if (c != mact[d] && pa == 0) begin
                    if (pn == 0) take = 1'b1;
                    else mhold[d] = 1;
                end else begin
                    ps[d] = (na == 1);
                    lv[d] = (na > 1) && (ph < nsel / 2);
                end
            end else if (pn == 0) begin
                take = 1'b1;
            end
            if (take) begin
                mact[d]  = c;
                mhold[d] = 0;
                ps[d] = (nn == 1);
                lv[d] = (nn > 1);
            end
        end
        for (int o = 0; o < 2; o++) begin
            int src;
            logic en, live;
            src  = (o == 1 && s) ? 1 : 0;
            en   = (o == 0) ? e0 : e1;
            live = en & ~f;
            hi[3-o] = live & (lv[src] | ps[src]);
            lo[3-o] = live & lv[src];
            hi[1-o] = en;
            lo[1-o] = en;
        end
        exp_hi_nxt = hi;
        exp_lo_nxt = lo;
        mc = (mc + 1) % 240;
    endtask

    task automatic model_init();
        mact[0] = 0; mact[1] = 0; mhold[0] = 0; mhold[1] = 0; mc = 0;
    endtask

    // one cycle: check high half, drive, predict, check low half
    task automatic run_cycle(input vec_t v, input string tag);
        @(posedge clk);
        #2;
        exp_hi_cur = exp_hi_nxt;
        exp_lo_cur = exp_lo_nxt;
        chk(tag, {clk0, clk1, oe0, oe1}, exp_hi_cur);
        #2;
        d0 = v.c0; d1 = v.c1; s = v.s; f = v.f; e0 = v.e0; e1 = v.e1;
        model_step();
        #8;
        chk(tag, {clk0, clk1, oe0, oe1}, exp_lo_cur);
    endtask

    // R9: one reset cycle checked, then release with the model restarted
    task automatic release_reset(input vec_t v);
        @(posedge clk);
        #2;
        chk("R9", {clk0, clk1, oe0, oe1}, 4'b0011);
        #2;
        rst = 1'b0;
        d0 = v.c0; d1 = v.c1; s = v.s; f = v.f; e0 = v.e0; e1 = v.e1;
        model_init();
        model_step();
        #8;
        chk("R9", {clk0, clk1, oe0, oe1}, 4'b0011);
    endtask

    initial begin
        #(20 * 200000);
        n_err++;
        $display("FAIL watchdog expired: got running expected finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        release_reset(VECS[0]);
        for (int i = 0; i < NV; i++) begin
            for (int k = 0; k < int'(VECS[i].len); k++) begin
                run_cycle(VECS[i], tag_of(VECS[i].kind));
            end
        end

        // R9: reset in mid-run with output 0 disabled; flags return high
        run_cycle('{8'h40, 8'h60, 1'b1, 1'b0, 1'b0, 1'b1, 8'd1, 4'd8}, "R8");
        @(posedge clk);
        #4 rst = 1'b1;
        @(posedge clk);
        #2 chk("R9", {clk0, clk1, oe0, oe1}, 4'b0011);
        #10 chk("R9", {clk0, clk1, oe0, oe1}, 4'b0011);
        // after reset both dividers start at ratio 1, then move to 3 and 4
        release_reset('{8'h40, 8'h60, 1'b1, 1'b0, 1'b1, 1'b1, 8'd1, 4'd3});
        for (int k = 0; k < 30; k++) begin
            run_cycle('{8'h40, 8'h60, 1'b1, 1'b0, 1'b1, 1'b1, 8'd1, 4'd3}, "R9");
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule